// File: doc/BRIEF.md
# Encrypted Flash Region Decrypt Selector

This block sits beside the flash read path and classifies every read address in the same cycle it is presented. A 640 KB flash space is cut into three encryption windows that start on 256 KB boundaries. The first two windows are 256 KB each and the third is 128 KB. Every window is split into 8 KB sub-regions, and each sub-region has its own enable bit. For a read address the block raises a decrypt flag when the containing sub-region is marked encrypted. It also names the window, which selects that window's key/IV slot in a downstream cipher. Finally it presents the 64-bit-aligned block address that the cipher uses as its tweak.

Software or a boot loader programs one enable register per window through a small write/read port. A lock input freezes the whole configuration until the next reset, so a boot stage can seal its settings before handing over control. The decode is purely combinational and adds no cycles to the read path. The cipher, key storage and flash timing belong to other blocks.

Top module: `flash_crypt_sel`

## Requirements
- R1: After reset every enable bit is zero and the lock is clear, so every read address produces `dec_en` low and each register reads back as zero.
- R2: For an address below 0xA0000, bits 19:18 select the window (0x00000-0x3FFFF is 0, 0x40000-0x7FFFF is 1, 0x80000-0x9FFFF is 2), and `key_slot` equals that window number.
- R3: Within a window, address bits 17:13 pick the enable bit (bit n covers the nth 8 KB sub-region from the window base), and `dec_en` equals that bit.
- R4: Window 2 keeps only 16 enable bits (bits 15:0). Writes to bits 31:16 of its register have no effect, and those bits read back as zero.
- R5: Any address at or above 0xA0000 gives `dec_en` low and `key_slot` zero, whatever the registers hold.
- R6: While `lock_in` is high, and in every cycle after it has been high once, register writes are ignored. Only reset clears the lock; dropping `lock_in` does not.
- R7: `dec_en`, `key_slot` and `blk_addr` follow `rd_addr` in the same cycle, with no register on the path.
- R8: `blk_addr` equals `rd_addr` bits 19:3, the index of the 64-bit block holding the address.
- R9: A write with `cfg_we` high and `cfg_sel` 0, 1 or 2 loads `cfg_wdata` into that window's register at the clock edge. `cfg_rdata` shows the register chosen by `cfg_rsel` in the same cycle. `cfg_sel` or `cfg_rsel` of 3 addresses nothing: the write is dropped and the read returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_in | input | 1 | Freezes the configuration until reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Window register targeted by the write |
| cfg_wdata | input | 32 | Write data, one bit per sub-region |
| cfg_rsel | input | 2 | Window register selected for read-back |
| cfg_rdata | output | 32 | Read-back of the selected register |
| rd_addr | input | 20 | Flash byte address of the current read |
| dec_en | output | 1 | Data of this address must go through the cipher |
| key_slot | output | 2 | Key/IV slot of the containing window |
| blk_addr | output | 17 | 64-bit block address used as the cipher tweak |

## Verification
The hardest case is the lock taking hold in the same cycle as a write. The stimulus raises `lock_in` in exactly the cycle that carries a write of a new pattern, then lowers it and issues further writes. Read-back and decoded reads must still show the pattern set before the lock. A second hard area is the edge of the third window: its upper enable bits do not exist, and addresses just past 0xA0000 alias onto bit 16 of its register. The bench writes all ones there and then probes both sides of that boundary.

// File: rtl/fcs_pkg.sv
// Shared constants and helpers for the encrypted flash region selector.
// Assumes byte addressing and power-of-two window and sub-region sizes.
package fcs_pkg;

    // Default geometry of the protected flash space
    localparam int unsigned FCS_ADDR_W       = 20;
    localparam int unsigned FCS_FLASH_BYTES  = 32'h000A_0000;
    localparam int unsigned FCS_REGION_SHIFT = 18;
    localparam int unsigned FCS_SUB_SHIFT    = 13;
    localparam int unsigned FCS_BLK_SHIFT    = 3;

    // Number of windows needed to cover the flash space
    function automatic int unsigned fcs_num_regions(input int unsigned flash_bytes,
                                                    input int unsigned region_shift);
        int unsigned rb;
        rb = 32'd1 << region_shift;
        return (flash_bytes + rb - 1) / rb;
    endfunction

    // Number of sub-regions actually backed by flash inside window r
    function automatic int unsigned fcs_subs_in(input int unsigned r,
                                                input int unsigned flash_bytes,
                                                input int unsigned region_shift,
                                                input int unsigned sub_shift);
        int unsigned rb;
        int unsigned base;
        int unsigned span;
        rb   = 32'd1 << region_shift;
        base = r * rb;
        span = (flash_bytes - base >= rb) ? rb : (flash_bytes - base);
        return span >> sub_shift;
    endfunction

endpackage

// File: rtl/fcs_lock_ctrl.sv
// Sticky configuration lock.
// Holds a flag that sets on the first cycle lock_in is high and clears only
// on reset. wr_block is high whenever a register write must be refused,
// including the very cycle in which lock_in first rises.
module fcs_lock_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_in,
    output logic locked,
    output logic wr_block
);

    logic lock_q;

    // Purpose: remember that the lock has been requested since reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (lock_in) begin
            lock_q <= 1'b1;
        end
    end

    // Purpose: refuse writes in the request cycle and every cycle after it
    always_comb begin
        wr_block = lock_q | lock_in;
    end

    assign locked = lock_q;

endmodule

// File: rtl/fcs_cfg_bank.sv
// Per-window sub-region enable registers.
// One register per window. Only the sub-regions backed by flash get a flop;
// missing bits are tied to zero, so they ignore writes and read as zero.
// The full bitmap of all windows is exported flat for the address decoder.
// Assumes REG_W equals the number of sub-regions in a full window.
module fcs_cfg_bank #(
    parameter int unsigned NUM_REGIONS  = 3,
    parameter int unsigned REG_W        = 32,
    parameter int unsigned SEL_W        = 2,
    parameter int unsigned FLASH_BYTES  = 32'h000A_0000,
    parameter int unsigned REGION_SHIFT = 18,
    parameter int unsigned SUB_SHIFT    = 13
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         wr_block,
    input  logic [SEL_W-1:0]             wr_sel,
    input  logic [REG_W-1:0]             wr_data,
    input  logic [SEL_W-1:0]             rd_sel,
    output logic [REG_W-1:0]             rd_data,
    output logic [NUM_REGIONS*REG_W-1:0] en_flat
);

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        localparam int unsigned NSUB =
            fcs_pkg::fcs_subs_in(r, FLASH_BYTES, REGION_SHIFT, SUB_SHIFT);

        logic [NSUB-1:0] bits_q;
        logic            hit;

        // Purpose: decode whether this window's register is the write target
        always_comb begin
            hit = wr_en && !wr_block && (wr_sel == SEL_W'(r));
        end

        // Purpose: hold the backed enable bits of this window
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bits_q <= '0;
            end else if (hit) begin
                bits_q <= wr_data[NSUB-1:0];
            end
        end

        if (NSUB < REG_W) begin : g_partial
            assign en_flat[r*REG_W +: REG_W] = {{(REG_W-NSUB){1'b0}}, bits_q};
        end else begin : g_full
            assign en_flat[r*REG_W +: REG_W] = bits_q;
        end
    end

    // Purpose: return the register picked by rd_sel, zero for an empty select
    always_comb begin
        rd_data = '0;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (rd_sel == SEL_W'(r)) begin
                rd_data = en_flat[r*REG_W +: REG_W];
            end
        end
    end

endmodule

// File: rtl/fcs_addr_decode.sv
// Combinational read-address classifier.
// Splits the byte address into window, sub-region and 64-bit block index,
// looks up the enable bit and produces the cipher controls with no flop on
// the path. Assumes windows are aligned to 1 << REGION_SHIFT.
module fcs_addr_decode #(
    parameter int unsigned ADDR_W       = 20,
    parameter int unsigned NUM_REGIONS  = 3,
    parameter int unsigned REG_W        = 32,
    parameter int unsigned SEL_W        = 2,
    parameter int unsigned FLASH_BYTES  = 32'h000A_0000,
    parameter int unsigned REGION_SHIFT = 18,
    parameter int unsigned SUB_SHIFT    = 13,
    parameter int unsigned BLK_SHIFT    = 3
) (
    input  logic [ADDR_W-1:0]            addr,
    input  logic [NUM_REGIONS*REG_W-1:0] en_flat,
    output logic                         dec_en,
    output logic [SEL_W-1:0]             key_slot,
    output logic [ADDR_W-BLK_SHIFT-1:0]  blk_addr
);

    localparam int unsigned RIDX_W = ADDR_W - REGION_SHIFT;
    localparam int unsigned SIDX_W = REGION_SHIFT - SUB_SHIFT;

    logic [RIDX_W-1:0] region_idx;
    logic [SIDX_W-1:0] sub_idx;
    logic              in_range;
    logic [REG_W-1:0]  win_bits;

    // Purpose: split the address into its window and sub-region fields
    always_comb begin
        region_idx = addr[ADDR_W-1:REGION_SHIFT];
        sub_idx    = addr[REGION_SHIFT-1:SUB_SHIFT];
        in_range   = (addr < ADDR_W'(FLASH_BYTES));
    end

    // Purpose: fetch the enable bitmap of the addressed window
    always_comb begin
        win_bits = '0;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (region_idx == RIDX_W'(r)) begin
                win_bits = en_flat[r*REG_W +: REG_W];
            end
        end
    end

    // Purpose: drive the cipher controls for the current read
    always_comb begin
        dec_en   = in_range && win_bits[sub_idx];
        key_slot = in_range ? SEL_W'(region_idx) : '0;
        blk_addr = addr[ADDR_W-1:BLK_SHIFT];
    end

endmodule

// File: rtl/flash_crypt_sel.sv
// Encrypted flash region decrypt selector, top level.
// Ties together the sticky lock, the per-window enable registers and the
// zero-latency address classifier. Assumes the downstream cipher picks its
// key/IV pair from key_slot and uses blk_addr as the tweak.
module flash_crypt_sel #(
    parameter int unsigned ADDR_W       = fcs_pkg::FCS_ADDR_W,
    parameter int unsigned FLASH_BYTES  = fcs_pkg::FCS_FLASH_BYTES,
    parameter int unsigned REGION_SHIFT = fcs_pkg::FCS_REGION_SHIFT,
    parameter int unsigned SUB_SHIFT    = fcs_pkg::FCS_SUB_SHIFT,
    parameter int unsigned BLK_SHIFT    = fcs_pkg::FCS_BLK_SHIFT,
    localparam int unsigned NUM_REGIONS =
        fcs_pkg::fcs_num_regions(FLASH_BYTES, REGION_SHIFT),
    localparam int unsigned REG_W       = 1 << (REGION_SHIFT - SUB_SHIFT),
    localparam int unsigned SEL_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS + 1) : 1,
    localparam int unsigned BLK_W       = ADDR_W - BLK_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_in,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic [SEL_W-1:0]  cfg_rsel,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              dec_en,
    output logic [SEL_W-1:0]  key_slot,
    output logic [BLK_W-1:0]  blk_addr
);

    logic                         locked;
    logic                         wr_block;
    logic [NUM_REGIONS*REG_W-1:0] en_flat;

    fcs_lock_ctrl u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_in  (lock_in),
        .locked   (locked),
        .wr_block (wr_block)
    );

    fcs_cfg_bank #(
        .NUM_REGIONS  (NUM_REGIONS),
        .REG_W        (REG_W),
        .SEL_W        (SEL_W),
        .FLASH_BYTES  (FLASH_BYTES),
        .REGION_SHIFT (REGION_SHIFT),
        .SUB_SHIFT    (SUB_SHIFT)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_block (wr_block),
        .wr_sel   (cfg_sel),
        .wr_data  (cfg_wdata),
        .rd_sel   (cfg_rsel),
        .rd_data  (cfg_rdata),
        .en_flat  (en_flat)
    );

    fcs_addr_decode #(
        .ADDR_W       (ADDR_W),
        .NUM_REGIONS  (NUM_REGIONS),
        .REG_W        (REG_W),
        .SEL_W        (SEL_W),
        .FLASH_BYTES  (FLASH_BYTES),
        .REGION_SHIFT (REGION_SHIFT),
        .SUB_SHIFT    (SUB_SHIFT),
        .BLK_SHIFT    (BLK_SHIFT)
    ) u_dec (
        .addr     (rd_addr),
        .en_flat  (en_flat),
        .dec_en   (dec_en),
        .key_slot (key_slot),
        .blk_addr (blk_addr)
    );

endmodule

// File: rtl/fcs_checker.sv
// Property checker for the decrypt selector, bound into every instance.
// Watches the ports plus the lock flag and the flat enable bitmap.
module fcs_checker #(
    parameter int unsigned ADDR_W       = 20,
    parameter int unsigned NUM_REGIONS  = 3,
    parameter int unsigned REG_W        = 32,
    parameter int unsigned SEL_W        = 2,
    parameter int unsigned FLASH_BYTES  = 32'h000A_0000,
    parameter int unsigned REGION_SHIFT = 18
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         lock_in,
    input logic                         cfg_we,
    input logic [SEL_W-1:0]             cfg_sel,
    input logic [REG_W-1:0]             cfg_wdata,
    input logic [ADDR_W-1:0]            rd_addr,
    input logic                         dec_en,
    input logic [SEL_W-1:0]             key_slot,
    input logic                         locked,
    input logic [NUM_REGIONS*REG_W-1:0] en_flat
);

    // R1: the first cycle after reset shows a clean configuration
    assert_reset_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (en_flat == '0) && !locked);

    // R5: out-of-range reads never decrypt and use slot zero
    assert_oor_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr >= ADDR_W'(FLASH_BYTES)) |-> !dec_en && (key_slot == '0));

    // R2: a decrypting read always carries its own window's slot
    assert_slot_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_en |-> (key_slot == SEL_W'(rd_addr >> REGION_SHIFT)));

    // R6: once locked, the lock stays set
    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(locked) |-> locked);

    // R6: the bitmap cannot change in the cycle lock_in rises or afterwards
    assert_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(locked) || $past(lock_in)) |-> $stable(en_flat));

    // R9: an accepted write to window 0 lands in full
    assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_we && !lock_in && !locked && (cfg_sel == '0))
        |-> (en_flat[REG_W-1:0] == $past(cfg_wdata)));

endmodule

bind flash_crypt_sel fcs_checker #(
    .ADDR_W       (ADDR_W),
    .NUM_REGIONS  (NUM_REGIONS),
    .REG_W        (REG_W),
    .SEL_W        (SEL_W),
    .FLASH_BYTES  (FLASH_BYTES),
    .REGION_SHIFT (REGION_SHIFT)
) u_fcs_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_in   (lock_in),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .rd_addr   (rd_addr),
    .dec_en    (dec_en),
    .key_slot  (key_slot),
    .locked    (locked),
    .en_flat   (en_flat)
);

// File: tb/tb_flash_crypt_sel.sv
// Directed bench for the decrypt selector: one task per scenario.
module tb_flash_crypt_sel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_in = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  cfg_rsel = '0;
    logic [31:0] cfg_rdata;
    logic [19:0] rd_addr = '0;
    logic        dec_en;
    logic [1:0]  key_slot;
    logic [16:0] blk_addr;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Bench copy of the programmed registers, per the requirements
    logic [31:0] exp_reg [3];

    always #10 clk = ~clk;

    flash_crypt_sel dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_in   (lock_in),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rsel  (cfg_rsel),
        .cfg_rdata (cfg_rdata),
        .rd_addr   (rd_addr),
        .dec_en    (dec_en),
        .key_slot  (key_slot),
        .blk_addr  (blk_addr)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected decrypt flag from R2, R3, R5
    function automatic logic exp_dec(input logic [19:0] a);
        if (a >= 20'hA0000) return 1'b0;
        return exp_reg[a[19:18]][a[17:13]];
    endfunction

    function automatic logic [1:0] exp_slot(input logic [19:0] a);
        return (a >= 20'hA0000) ? 2'd0 : a[19:18];
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        lock_in = 1'b0;
        cfg_we = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) exp_reg[i] = '0;
    endtask

    task automatic write_reg(input logic [1:0] sel, input logic [31:0] d,
                             input logic lk);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_sel = sel;
        cfg_wdata = d;
        lock_in = lk;
        @(negedge clk);
        cfg_we = 1'b0;
        lock_in = 1'b0;
    endtask

    task automatic probe(input string req, input logic [19:0] a);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(req, $sformatf("dec_en @%h", a), {31'd0, dec_en}, {31'd0, exp_dec(a)});
        check(req, $sformatf("key_slot @%h", a), {30'd0, key_slot}, {30'd0, exp_slot(a)});
    endtask

    task automatic readback(input string req, input logic [1:0] s,
                            input logic [31:0] exp);
        @(negedge clk);
        cfg_rsel = s;
        #1;
        check(req, $sformatf("rdata sel %0d", s), cfg_rdata, exp);
    endtask

    // R1: reset state
    task automatic t_reset();
        do_reset();
        for (int i = 0; i < 3; i++) readback("R1", 2'(i), 32'd0);
        probe("R1", 20'h00000);
        probe("R1", 20'h5E000);
        probe("R1", 20'h9E000);
    endtask

    // R2, R9: window selection with every bit set
    task automatic t_region_decode();
        for (int i = 0; i < 3; i++) begin
            write_reg(2'(i), 32'hFFFF_FFFF, 1'b0);
            exp_reg[i] = (i == 2) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
        end
        readback("R9", 2'd0, 32'hFFFF_FFFF);
        readback("R9", 2'd1, 32'hFFFF_FFFF);
        probe("R2", 20'h00100);
        probe("R2", 20'h3FFFF);
        probe("R2", 20'h40000);
        probe("R2", 20'h7FFF8);
        probe("R2", 20'h80000);
        probe("R2", 20'h9FFFF);
    endtask

    // R3: individual sub-region bits
    task automatic t_subregion();
        write_reg(2'd1, 32'h0000_0005, 1'b0);
        exp_reg[1] = 32'h0000_0005;
        write_reg(2'd0, 32'h8000_0000, 1'b0);
        exp_reg[0] = 32'h8000_0000;
        probe("R3", 20'h40000);
        probe("R3", 20'h42000);
        probe("R3", 20'h44000);
        probe("R3", 20'h45FFF);
        probe("R3", 20'h7E000);
        probe("R3", 20'h3E000);
        probe("R3", 20'h3DFFF);
        probe("R3", 20'h00000);
    endtask

    // R4: window 2 has only sixteen bits
    task automatic t_region2_mask();
        write_reg(2'd2, 32'hFFFF_8001, 1'b0);
        exp_reg[2] = 32'h0000_8001;
        readback("R4", 2'd2, 32'h0000_8001);
        probe("R4", 20'h80000);
        probe("R4", 20'h82000);
        probe("R4", 20'h9E000);
    endtask

    // R5: addresses past the end of the flash space
    task automatic t_out_of_range();
        write_reg(2'd2, 32'hFFFF_FFFF, 1'b0);
        exp_reg[2] = 32'h0000_FFFF;
        probe("R5", 20'h9FFF8);
        probe("R5", 20'hA0000);
        probe("R5", 20'hBE000);
        probe("R5", 20'hC0000);
        probe("R5", 20'hFFFFF);
    endtask

    // R9: a select of 3 addresses nothing
    task automatic t_bad_select();
        write_reg(2'd3, 32'h1234_5678, 1'b0);
        readback("R9", 2'd3, 32'd0);
        readback("R9", 2'd0, exp_reg[0]);
        readback("R9", 2'd1, exp_reg[1]);
        readback("R9", 2'd2, exp_reg[2]);
    endtask

    // R7, R8: same-cycle response and block address
    task automatic t_comb_blk();
        @(negedge clk);
        rd_addr = 20'h12345;
        #1;
        check("R8", "blk_addr", {15'd0, blk_addr}, 32'h0000_2468);
        rd_addr = 20'h44007;
        #1;
        check("R7", "dec_en same cycle", {31'd0, dec_en}, {31'd0, exp_dec(20'h44007)});
        check("R8", "blk_addr same cycle", {15'd0, blk_addr}, 32'h0000_8800);
        rd_addr = 20'h42000;
        #1;
        check("R7", "dec_en falls same cycle", {31'd0, dec_en}, 32'd0);
    endtask

    // R6: lock in the write cycle, stays after lock_in drops, reset clears
    task automatic t_lock();
        do_reset();
        write_reg(2'd0, 32'h0000_00AA, 1'b0);
        exp_reg[0] = 32'h0000_00AA;
        write_reg(2'd0, 32'h0000_0055, 1'b1);
        readback("R6", 2'd0, 32'h0000_00AA);
        write_reg(2'd1, 32'hFFFF_FFFF, 1'b0);
        readback("R6", 2'd1, 32'd0);
        probe("R6", 20'h40000);
        probe("R6", 20'h02000);
        do_reset();
        readback("R6", 2'd0, 32'd0);
        write_reg(2'd1, 32'h0000_0001, 1'b0);
        exp_reg[1] = 32'h0000_0001;
        readback("R6", 2'd1, 32'h0000_0001);
        probe("R6", 20'h40000);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_region_decode();
        t_subregion();
        t_region2_mask();
        t_out_of_range();
        t_bad_select();
        t_comb_blk();
        t_lock();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule